// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Controller

This block collects eight single-cycle event pulses from a bus-host style controller. It latches each pulse into a status word at a fixed, sparse bit position and drives one interrupt line. Software controls which sources may interrupt through a single enable mask. The mask has two write paths: one address where written ones turn mask bits on, and another where written ones turn mask bits off. In both cases a written zero leaves the bit alone. A read from either address returns the same mask, so software never keeps a shadow copy.

The most significant mask bit is a master enable. While it is clear, no source can raise the interrupt, and latched status is kept. Status bits are cleared by writing ones to the status address. The register bus is a plain address, write strobe and write data, with a combinational read-data return.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the enable mask (master bit included) and the status word are all zero, and `irq_out` is low.
- R2: A write to offset 0x10 sets every valid mask bit whose data bit is 1. Mask bits written with 0 keep their value.
- R3: A write to offset 0x14 clears every mask bit whose data bit is 1. Mask bits written with 0 keep their value.
- R4: Reads from offset 0x10 and offset 0x14 both return the current enable mask.
- R5: Mask bits 29 to 7 and status bits 31 and 29 to 7 always read as zero, and writes to them have no effect.
- R6: Input `evt_pulse[k]` for k in 0..6 sets status bit k. `evt_pulse[7]` sets status bit 30. Status holds its value when there is no event and no clear.
- R7: A write to offset 0x0C clears each status bit whose data bit is 1. An event on the same cycle keeps its bit set.
- R8: `irq_out` is high exactly when mask bit 31 is set and, for some bit position, both the status bit and the mask bit are set.
- R9: Clearing mask bit 31 through offset 0x14 forces `irq_out` low from the next cycle, while latched status is kept.
- R10: Writes to any other offset change nothing, and reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 8 | One-cycle event pulses, index 7 maps to status bit 30 |
| irq_out | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check how the mask responds to the set and clear paths, how it holds when neither is written, how events latch into status and how status clears, and that the line falls after a master-disable write. Several things only show at the ports under chosen scenarios: that both offsets read back the same mask, the sparse mapping of event 7 onto bit 30, that an event wins over a simultaneous clear, and that unused offsets and reserved bits stay silent. The bench covers these with directed sequences and with a pseudo-random stream compared against its reference model on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned N_EVT   = 8;
  localparam int unsigned MIE_POS = DATA_W - 1;
  localparam int unsigned HI_POS  = DATA_W - 2;

  localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_EN_SET = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = ADDR_W'('h14);

  // Bit position of event source idx: the top source sits just below the master bit
  function automatic int unsigned evt_pos(input int unsigned idx);
    return (idx == N_EVT - 1) ? HI_POS : idx;
  endfunction

  function automatic logic [DATA_W-1:0] status_valid();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < N_EVT; i++) m[evt_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] enable_valid();
    logic [DATA_W-1:0] m;
    m = status_valid();
    m[MIE_POS] = 1'b1;
    return m;
  endfunction

  // Interrupt condition: master bit and any enabled latched source
  function automatic logic irq_from(input logic [DATA_W-1:0] st,
                                    input logic [DATA_W-1:0] en);
    return en[MIE_POS] & (|(st & en & status_valid()));
  endfunction
endpackage

// File: rtl/irq_evt_map.sv
module irq_evt_map
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NE = N_EVT,
  parameter int unsigned DW = DATA_W
) (
  input  logic [NE-1:0] evt,
  output logic [DW-1:0] evt_bits
);
  logic [NE-1:0][DW-1:0] lane;

  for (genvar g = 0; g < NE; g++) begin : g_lane
    always_comb begin
      lane[g] = '0;
      lane[g][evt_pos(g)] = evt[g];
    end
  end

  always_comb begin
    evt_bits = '0;
    for (int i = 0; i < NE; i++) evt_bits = evt_bits | lane[i];
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_bits,
  input  logic          clr_wr,
  input  logic [DW-1:0] clr_bits,
  output logic [DW-1:0] status_q
);
  localparam logic [DW-1:0] VALID = status_valid();

  logic [DW-1:0] clr_eff;
  logic [DW-1:0] status_d;

  assign clr_eff  = clr_wr ? clr_bits : '0;
  assign status_d = ((status_q & ~clr_eff) | set_bits) & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((status_q & $past(set_bits)) == $past(set_bits))); // R6
  AST_CLR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && set_bits == '0) |=> ((status_q & $past(clr_bits)) == '0)); // R7
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && set_bits == '0) |=> $stable(status_q)); // R6
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_wr,
  input  logic          clr_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_q
);
  localparam logic [DW-1:0] VALID = enable_valid();

  logic [DW-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (set_wr)      en_d = en_q | (wdata & VALID);
    else if (clr_wr) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  AST_SET_W1S: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((en_q & $past(wdata & VALID)) == $past(wdata & VALID))); // R2
  AST_CLR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr) |=> ((en_q & $past(wdata)) == '0)); // R3
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr || clr_wr) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata)))); // R2 R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr) |=> $stable(en_q)); // R10
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NE = N_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NE-1:0] evt_pulse,
  output logic          irq_out
);
  // Named decode events for the assertions
  logic          hit_status, hit_en_set, hit_en_clr;
  logic          wr_status, wr_en_set, wr_en_clr;
  logic [DW-1:0] evt_bits, status_q, en_q;

  assign hit_status = (bus_addr == AW'(OFS_STATUS));
  assign hit_en_set = (bus_addr == AW'(OFS_EN_SET));
  assign hit_en_clr = (bus_addr == AW'(OFS_EN_CLR));
  assign wr_status  = bus_wr & hit_status;
  assign wr_en_set  = bus_wr & hit_en_set;
  assign wr_en_clr  = bus_wr & hit_en_clr;

  irq_evt_map #(.NE(NE), .DW(DW)) u_map (
    .evt      (evt_pulse),
    .evt_bits (evt_bits)
  );

  irq_status_reg #(.DW(DW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (evt_bits),
    .clr_wr   (wr_status),
    .clr_bits (bus_wdata),
    .status_q (status_q)
  );

  irq_enable_reg #(.DW(DW)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (wr_en_set),
    .clr_wr (wr_en_clr),
    .wdata  (bus_wdata),
    .en_q   (en_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_status)                   bus_rdata = status_q;
    else if (hit_en_set || hit_en_clr) bus_rdata = en_q;
  end

  assign irq_out = irq_from(status_q, en_q);

  AST_ONE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_status, wr_en_set, wr_en_clr})); // R10
  AST_MIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_clr && bus_wdata[MIE_POS]) |=> !irq_out); // R9
  AST_MIE_KEEP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_clr && evt_pulse == '0) |=> $stable(status_q)); // R9
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_mask_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .irq_out(irq_out)
  );

  // Reference model, written from the requirements
  logic [31:0] m_en, m_st;

  function automatic logic [31:0] ev_word(input logic [7:0] e);
    logic [31:0] r = '0;
    for (int i = 0; i < 7; i++) r[i] = e[i];
    r[30] = e[7];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h0C:        return m_st;
      8'h10, 8'h14: return m_en;
      default:      return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0;
      m_st <= '0;
    end else begin
      if (bus_wr && bus_addr == 8'h10)      m_en <= (m_en | bus_wdata) & 32'hC000_007F;
      else if (bus_wr && bus_addr == 8'h14) m_en <= m_en & ~bus_wdata;
      m_st <= (((bus_wr && bus_addr == 8'h0C) ? (m_st & ~bus_wdata) : m_st)
               | ev_word(evt_pulse)) & 32'h4000_007F;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq", {31'b0, irq_out}, {31'b0, m_en[31] && ((m_st & m_en) != 0)});
      chk("R4 rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #2 bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #2 bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); #2 evt_pulse = e;
    @(negedge clk); #2 evt_pulse = '0;
  endtask

  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk); #2 bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_pulse = e;
    @(negedge clk); #2 bus_wr = 1'b0; evt_pulse = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #2 bus_addr = a; bus_wr = 1'b0;
    #3 chk(tag, bus_rdata, exp);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(negedge clk); #5 chk(tag, {31'b0, irq_out}, {31'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    rd(8'h0C, 32'h0, "R1 status after reset");
    rd(8'h10, 32'h0, "R1 mask after reset");
    irq_is(1'b0, "R1 irq after reset");

    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'hC000_007F, "R2 R5 set all");
    rd(8'h14, 32'hC000_007F, "R4 clear view reads mask");
    wr(8'h14, 32'h0000_0005);
    rd(8'h10, 32'hC000_007A, "R3 clear ones");
    wr(8'h14, 32'h0);
    rd(8'h14, 32'hC000_007A, "R3 zero keeps");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'hC000_007A, "R2 zero keeps");

    pulse(8'h81);
    rd(8'h0C, 32'h4000_0001, "R6 event map");
    irq_is(1'b1, "R8 bit30 enabled");
    wr(8'h14, 32'h4000_0000);
    irq_is(1'b0, "R8 no enabled source");
    wr(8'h10, 32'h0000_0001);
    irq_is(1'b1, "R8 bit0 enabled");
    wr(8'h14, 32'h8000_0000);
    irq_is(1'b0, "R9 master off");
    rd(8'h0C, 32'h4000_0001, "R9 status kept");
    wr(8'h10, 32'h8000_0000);
    irq_is(1'b1, "R9 master on");

    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, 32'h4000_0000, "R7 clear status bit");
    irq_is(1'b0, "R7 irq after clear");
    wr_evt(8'h0C, 32'hFFFF_FFFF, 8'h04);
    rd(8'h0C, 32'h0000_0004, "R7 event wins");

    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h10, 32'h8000_007B, "R10 other offset no write");
    rd(8'h20, 32'h0, "R10 other offset reads zero");
    wr(8'h10, 32'h3FFF_FF80);
    rd(8'h10, 32'h8000_007B, "R5 reserved ignored");
    pulse(8'h7F);
    rd(8'h0C, 32'h0000_007F, "R5 R6 low events");

    begin
      logic [31:0] lfsr = 32'h1234_5678;
      for (int n = 0; n < 600; n++) begin
        @(negedge clk); #2;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        case (lfsr[3:2])
          2'd0: bus_addr = 8'h0C;
          2'd1: bus_addr = 8'h10;
          2'd2: bus_addr = 8'h14;
          default: bus_addr = 8'h18;
        endcase
        bus_wr    = lfsr[5] & lfsr[7];
        bus_wdata = {lfsr[31:24] ^ lfsr[7:0], lfsr[23:0]};
        evt_pulse = (lfsr[9] & lfsr[11]) ? lfsr[19:12] : 8'h00;
      end
      @(negedge clk); #2 bus_wr = 1'b0; evt_pulse = '0;
    end

    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule